// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a single-port synchronous SRAM with a fully registered, zero-turnaround interface. Address and command are captured on one rising edge. Read data leaves the output register two enabled edges later. Write data is taken from the input bus in the same relative cycle. Because a read and a write use the data bus in the same slot, reads and writes can alternate on every enabled clock with no idle cycle between them.

Write data is held in a one-entry pending register and committed to the array on the next write's data edge. A read that hits the pending address gets the pending bytes merged over the array word, lane by lane. An active-low clock enable freezes every register. A two-bit burst counter lets a continuation cycle step the low address bits in linear or interleaved order.

The data bus has `LANES` lanes of `LW` bits each, usually 8 data bits plus 1 parity bit. Lane i occupies bits `[LW*i+LW-1 : LW*i]`. Lane i is written only when `bw_n[i]` is low.

Top module: `zbt_sram`

## Requirements
- R1: A read command loaded at enabled edge E drives the stored word on `dq_out` with `dq_oe` high right after the second enabled edge following E, provided `oe_n` is low.
- R2: While `cen_n` is high, no register changes. `dq_out` and the read/drive state hold, the burst position does not advance, and `dq_in` is ignored.
- R3: A load (`adv_ld` low) with all chip enables active writes only when `we_n` is low. Otherwise it reads. The write data is sampled from `dq_in` at the second enabled edge after the address.
- R4: Lane i (bits `[LW*i+LW-1:LW*i]`) is written only when `bw_n[i]` was low with that command. Lanes whose select was high keep their stored value.
- R5: A load starts a read or write only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Otherwise it is a deselect: nothing is written and `dq_oe` stays low in its data cycle.
- R6: `dq_oe` is low during the data cycle of a write and whenever `oe_n` is high.
- R7: Reads and writes may alternate on consecutive enabled clocks, each carrying one data transfer, with no idle cycle.
- R8: A read returns the most recent data written to its address, including a write whose data has not yet reached the array. Pending lanes are merged over the stored word per lane.
- R9: With `adv_ld` high, the next burst address keeps the upper address bits of the loaded address. For the k-th continuation, its two low bits are start XOR (k mod 4) when `burst_lin`=0, and (start + k) mod 4 when `burst_lin`=1.
- R10: A continuation repeats the operation type of the last load, including a deselect. `we_n` and the chip enables are ignored on continuation cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| cen_n | input | 1 | Active-low clock enable; high freezes the pipeline |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Active-low write command on a load |
| adv_ld | input | 1 | High: continue burst; low: load new address and command |
| burst_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| bw_n | input | LANES | Active-low per-lane write selects |
| addr | input | AW | Word address |
| dq_in | input | LANES*LW | Write data, sampled in the write data cycle |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_out | output | LANES*LW | Registered read data |
| dq_oe | output | 1 | High when the block drives the data bus |

## Verification
The clocked properties take for granted that every control input is a known value at each edge where `cen_n` is low. They also assume the address is wider than the two burst bits. Apart from the continuation assertion, they do not assume a load precedes a continuation; that one only fires once a real read or write has been loaded. The stimulus changes inputs only on falling edges, so each input stays stable around the rising edge. It always starts with a load after reset. During stall cycles it drives random values on `dq_in`, while the other inputs keep defined values.

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cen_n,
  input  logic                  ce1_n,
  input  logic                  ce2,
  input  logic                  ce3_n,
  input  logic                  we_n,
  input  logic                  adv_ld,
  input  logic                  burst_lin,
  input  logic [LANES-1:0]      bw_n,
  input  logic [AW-1:0]         addr,
  input  logic [LANES*LW-1:0]   dq_in,
  input  logic                  oe_n,
  output logic [LANES*LW-1:0]   dq_out,
  output logic                  dq_oe
);
  localparam int DW    = LANES * LW;
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {OP_NONE, OP_RD, OP_WR} op_t;

  logic            en, sel;
  op_t             last_op, s1_op, s2_op, nx_op;
  logic [AW-1:0]   base, s1_a, s2_a, nx_a;
  logic [1:0]      cnt, cnt_nx, lo;
  logic [LANES-1:0] s1_m, s2_m, pend_m;
  logic            pend_v, q_drv;
  logic [AW-1:0]   pend_a;
  logic [DW-1:0]   pend_d, q_reg, rd_word;
  logic [DW-1:0]   mem [DEPTH];

  assign en  = !cen_n;
  assign sel = !ce1_n && ce2 && !ce3_n;

  always_comb begin
    cnt_nx = adv_ld ? cnt + 2'd1 : 2'd0;
    lo     = burst_lin ? base[1:0] + cnt_nx : base[1:0] ^ cnt_nx;
    if (adv_ld) begin
      nx_op = last_op;
      nx_a  = {base[AW-1:2], lo};
    end else begin
      nx_op = sel ? (we_n ? OP_RD : OP_WR) : OP_NONE;
      nx_a  = addr;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_merge
    assign rd_word[i*LW +: LW] = (pend_v && pend_a == s2_a && pend_m[i])
                                 ? pend_d[i*LW +: LW] : mem[s2_a][i*LW +: LW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_op <= OP_NONE;
      s1_op   <= OP_NONE;
      s2_op   <= OP_NONE;
      cnt     <= '0;
      base    <= '0;
      s1_a    <= '0;
      s2_a    <= '0;
      s1_m    <= '0;
      s2_m    <= '0;
      q_drv   <= 1'b0;
      q_reg   <= '0;
      pend_v  <= 1'b0;
      pend_a  <= '0;
      pend_d  <= '0;
      pend_m  <= '0;
    end else if (en) begin
      last_op <= nx_op;
      cnt     <= cnt_nx;
      if (!adv_ld) base <= addr;
      s1_op <= nx_op;
      s1_a  <= nx_a;
      s1_m  <= ~bw_n;
      s2_op <= s1_op;
      s2_a  <= s1_a;
      s2_m  <= s1_m;
      q_drv <= (s2_op == OP_RD);
      if (s2_op == OP_RD) q_reg <= rd_word;
      if (s2_op == OP_WR) begin
        pend_v <= 1'b1;
        pend_a <= s2_a;
        pend_d <= dq_in;
        pend_m <= s2_m;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (en && s2_op == OP_WR && pend_v) begin
      for (int i = 0; i < LANES; i++)
        if (pend_m[i]) mem[pend_a][i*LW +: LW] <= pend_d[i*LW +: LW];
    end
  end

  assign dq_out = q_reg;
  assign dq_oe  = q_drv && !oe_n;

  a_r2_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> $stable(dq_out) && $stable(q_drv));

  a_r3_write_needs_we: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && we_n) |=> s1_op != OP_WR);

  a_r5_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld && (ce1_n || !ce2 || ce3_n)) |=> s1_op == OP_NONE);

  a_r6_release_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && s2_op == OP_WR) |=> !dq_oe);

  a_r9_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld && last_op != OP_NONE) |=> s1_a[AW-1:2] == $past(s1_a[AW-1:2]));
endmodule

// File: tb/test_zbt_sram.sv
module test_zbt_sram;
  localparam int AW = 6, LANES = 4, LW = 9, DW = LANES * LW, DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, cen_n = 1'b1, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic we_n = 1'b1, adv_ld = 1'b0, burst_lin = 1'b0, oe_n = 1'b0;
  logic [LANES-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0, dq_out;
  logic dq_oe;

  zbt_sram #(.AW(AW), .LANES(LANES), .LW(LW)) i_zbt_sram (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .we_n(we_n), .adv_ld(adv_ld), .burst_lin(burst_lin), .bw_n(bw_n), .addr(addr),
    .dq_in(dq_in), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe));

  always #5 clk = ~clk;

  typedef struct { bit drv; logic [DW-1:0] d; string tag; } exp_t;
  typedef struct { int op; logic [AW-1:0] a; logic [LANES-1:0] m; logic [DW-1:0] wd; string tag; } pop_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  logic [DW-1:0] model [DEPTH];
  pop_t p1 = '{0, '0, '0, '0, "R1"}, p2 = '{0, '0, '0, '0, "R1"};
  int last_op = 0, k = 0;
  logic [AW-1:0] b_base = '0;
  bit last_rd = 0;
  logic [DW-1:0] last_d = '0;
  bit done = 0;

  function automatic logic [DW-1:0] garbage();
    return DW'({$urandom, $urandom});
  endfunction

  function automatic logic [DW-1:0] pat(int i);
    return DW'({$urandom, 8'(i)}) ^ DW'(i * 36'h1_0203_0405);
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ce = {ce1_n, ce2, ce3_n}; active setting is 3'b010
  task automatic step(bit stall, bit adv, bit we, logic [2:0] ce, bit lin, bit oe,
                      logic [AW-1:0] a, logic [LANES-1:0] bwn, logic [DW-1:0] wd, string tag);
    pop_t n;
    exp_t e;
    logic [1:0] low;
    @(negedge clk);
    cen_n = stall; adv_ld = adv; we_n = we; {ce1_n, ce2, ce3_n} = ce;
    burst_lin = lin; oe_n = oe; addr = a; bw_n = bwn;
    dq_in = (!stall && p2.op == 2) ? p2.wd : garbage();
    n = '{0, a, ~bwn, wd, tag};
    if (!stall) begin
      if (adv) begin
        k = (k + 1) % 4;
        low = lin ? 2'(int'(b_base[1:0]) + k) : (b_base[1:0] ^ 2'(k));
        n.op = last_op;
        n.a = {b_base[AW-1:2], low};
      end else begin
        k = 0;
        b_base = a;
        n.op = (ce == 3'b010) ? (we ? 1 : 2) : 0;
        last_op = n.op;
      end
    end
    @(posedge clk);
    if (stall) begin
      e = '{last_rd && !oe, last_d, "R2"};
    end else begin
      last_rd = (p2.op == 1);
      if (last_rd) last_d = model[p2.a];
      e = '{last_rd && !oe, last_d, p2.tag};
      if (p2.op == 2)
        for (int i = 0; i < LANES; i++)
          if (p2.m[i]) model[p2.a][i*LW +: LW] = p2.wd[i*LW +: LW];
      p2 = p1;
      p1 = n;
    end
    q.push_back(e);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, logic [LANES-1:0] bwn, string tag);
    step(0, 0, 0, 3'b010, 0, 0, a, bwn, d, tag);
  endtask

  task automatic rd(logic [AW-1:0] a, string tag);
    step(0, 0, 1, 3'b010, 0, 0, a, '1, '0, tag);
  endtask

  initial begin : monitor
    exp_t e;
    wait (rst_n);
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(dq_oe == e.drv, e.tag, "drive", DW'(dq_oe), DW'(e.drv));
        if (e.drv) chk(dq_out == e.d, e.tag, "data", dq_out, e.d);
      end
    end
  end

  initial begin : watchdog
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 chk(dq_oe == 1'b0, "R5", "reset drive", DW'(dq_oe), '0);
    // R3: fill every word, back to back
    for (int i = 0; i < DEPTH; i++) wr(AW'(i), pat(i), '0, "R3");
    // R7 R8 R1: alternating writes and reads, including read right after write
    for (int i = 0; i < 16; i++) begin
      wr(AW'(i), pat(i + 100), '0, "R7");
      rd(AW'(i), "R8");
      rd(AW'(i + 32), "R1");
    end
    // R4: partial lane writes, forwarded and committed
    wr(6'd40, garbage(), 4'b1010, "R4");
    rd(6'd40, "R4");
    rd(6'd40, "R4");
    wr(6'd41, garbage(), 4'b0111, "R4");
    rd(6'd40, "R4");
    rd(6'd41, "R4");
    wr(6'd41, garbage(), 4'b1110, "R8");
    rd(6'd41, "R8");
    // R5: each chip enable inactive, including a write attempt
    step(0, 0, 0, 3'b110, 0, 0, 6'd5, '0, garbage(), "R5");
    step(0, 0, 1, 3'b000, 0, 0, 6'd5, '0, garbage(), "R5");
    step(0, 0, 0, 3'b011, 0, 0, 6'd5, '0, garbage(), "R5");
    rd(6'd5, "R5");
    // R10: continuation of a deselect stays idle, ignores we_n and enables
    step(0, 0, 1, 3'b111, 0, 0, 6'd6, '1, '0, "R10");
    step(0, 1, 0, 3'b010, 0, 0, 6'd0, '0, garbage(), "R10");
    step(0, 1, 0, 3'b010, 0, 0, 6'd0, '0, garbage(), "R10");
    rd(6'd6, "R10");
    // R2: stalls between a write and its data phase, and during read output
    wr(6'd7, pat(777), '0, "R2");
    rd(6'd7, "R2");
    for (int i = 0; i < 3; i++) step(1, 0, 0, 3'b010, 0, 0, 6'd9, '0, '0, "R2");
    rd(6'd8, "R2");
    for (int i = 0; i < 2; i++) step(1, 1, 0, 3'b110, 1, 0, 6'd3, '0, '0, "R2");
    rd(6'd7, "R2");
    // R9: interleaved write burst from offset 2, linear read burst from offset 2
    wr(6'd18, pat(18), '0, "R9");
    for (int i = 1; i < 4; i++) step(0, 1, 1, 3'b111, 0, 0, 6'd0, '0, pat(18 + i * 7), "R9");
    step(0, 0, 1, 3'b010, 1, 0, 6'd18, '1, '0, "R9");
    for (int i = 1; i < 4; i++) step(0, 1, 0, 3'b111, 1, 0, 6'd0, '1, '0, "R9");
    // linear write from offset 1 with a stall mid-burst, interleaved read with wrap
    wr(6'd21, pat(21), '0, "R9");
    step(0, 1, 1, 3'b010, 1, 0, 6'd0, '0, pat(22), "R9");
    step(1, 1, 1, 3'b010, 1, 0, 6'd0, '0, '0, "R2");
    for (int i = 2; i < 4; i++) step(0, 1, 1, 3'b010, 1, 0, 6'd0, '0, pat(21 + i), "R9");
    step(0, 0, 1, 3'b010, 0, 0, 6'd23, '1, '0, "R9");
    for (int i = 1; i < 5; i++) step(0, 1, 0, 3'b000, 0, 0, 6'd0, '1, '0, "R10");
    // R6: output enable high releases bus; write data cycle releases bus
    step(0, 0, 1, 3'b010, 0, 1, 6'd20, '1, '0, "R6");
    step(0, 0, 1, 3'b010, 0, 1, 6'd21, '1, '0, "R6");
    step(0, 0, 0, 3'b010, 0, 1, 6'd22, '0, pat(5), "R6");
    wr(6'd23, pat(6), '0, "R6");
    rd(6'd22, "R6");
    rd(6'd23, "R6");
    // drain
    for (int i = 0; i < 3; i++) step(0, 0, 1, 3'b111, 0, 0, 6'd0, '1, '0, "R5");
    repeat (3) @(posedge clk);
    #3;
    chk(q.size() == 0, "R1", "queue drained", DW'(q.size()), '0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule